// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a bus-mapped watchdog built around a down-counter. Software keeps the system alive by reloading the counter before it runs out. The first time the counter reaches zero, the block raises an interrupt and starts a fresh countdown from the load value. If the interrupt is still pending when the counter reaches zero a second time, the block asserts a system reset output. That output stays asserted until the block's own reset input clears it.

Register writes go through a simple synchronous bus with one write strobe and a combinational read path. A write-protection register guards every write. It admits writes only after a magic key has been stored in it, and any other value written to it shuts writes off again. A write to the load register or to the interrupt-clear register restarts the countdown, so either write serves as a keep-alive.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the load register (0x000) and the count (0x004) read 0xFFFFFFFF. The control register (0x008) reads 0. The lock register (0xC00) reads 1. Raw status (0x010) and masked status (0x014) read 0. The irq and sysRst outputs are low.
- R2: Writing 0x1ACCE551 to the lock register unlocks the block, and the lock register then reads 0. Writing any other value locks the block, and the lock register then reads 1. While the block is locked, writes to every other register are ignored.
- R3: A write to the load register updates the load value and the count at the same clock edge. A write of 0 is stored as 1. A load write takes priority over a countdown reload in the same cycle.
- R4: The count, read at 0x004, drops by one on each clock while control bit 0 is 1. It holds its value while control bit 0 is 0.
- R5: When the count is 0, control bit 0 is set and no interrupt is pending, the next edge sets raw status bit 0 and reloads the count from the load value.
- R6: When the count is 0 with the interrupt still pending, the count reloads. If control bit 1 is also set, sysRst goes high. Once high, sysRst stays high until the reset input is asserted, even after the interrupt is cleared.
- R7: A write of any value to the interrupt-clear register (0x00C) clears raw status bit 0 and reloads the count from the load value.
- R8: Masked status bit 0 equals raw status bit 0 ANDed with control bit 0. The irq output equals masked status bit 0.
- R9: An interrupt-clear write that lands in the same cycle as an expiry takes priority. At a first expiry the interrupt does not set. At a second expiry sysRst does not assert. In both cases the count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt, equal to masked status |
| sysRst | output | 1 | Sticky system reset request |

## Verification
Two functions can land on the same clock edge: an interrupt-clear write and a counter expiry. The bench lets the count run down to exactly zero, then issues the clear write so that it is sampled on the expiry edge. It does this once with no interrupt pending and once at the second stage. The bench judges the result by reading raw status, the count and sysRst on the following cycle: the interrupt must stay clear, the reset must stay low, and the count must equal the load value. A load write that lands on a decrement edge is checked the same way, to confirm the new value wins.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_ICLR  = 12'h00C;
  localparam logic [11:0] OFS_RAW   = 12'h010;
  localparam logic [11:0] OFS_MASK  = 12'h014;
  localparam logic [11:0] OFS_KEY   = 12'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  // Strobes from the register/control side to the counter datapath
  typedef struct packed {
    logic loadWr;   // load register written this cycle
    logic intClr;   // interrupt clear written this cycle
    logic cntEn;    // control bit 0
    logic rstEn;    // control bit 1
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              intRaw,
  output wdtStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadNew,
  output logic [CNT_W-1:0]  loadCur,
  output logic [31:0]       busRdata
);
  localparam logic [CNT_W-1:0] LOAD_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD_MIN = CNT_W'(1);

  logic             locked;
  logic [1:0]       ctrlReg;
  logic [CNT_W-1:0] loadReg;
  logic             wrOk;
  logic             hitLoad, hitCount, hitCtrl, hitIclr, hitRaw, hitMask, hitKey;

  always_comb begin
    hitLoad  = busAddr == ADDR_W'(OFS_LOAD);
    hitCount = busAddr == ADDR_W'(OFS_COUNT);
    hitCtrl  = busAddr == ADDR_W'(OFS_CTRL);
    hitIclr  = busAddr == ADDR_W'(OFS_ICLR);
    hitRaw   = busAddr == ADDR_W'(OFS_RAW);
    hitMask  = busAddr == ADDR_W'(OFS_MASK);
    hitKey   = busAddr == ADDR_W'(OFS_KEY);
  end

  assign wrOk = busWr & ~locked;

  always_comb begin
    if (busWdata[CNT_W-1:0] == '0) loadNew = LOAD_MIN;
    else                           loadNew = busWdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b1;
      ctrlReg <= 2'b00;
      loadReg <= LOAD_RST;
    end else begin
      if (busWr && hitKey) locked <= (busWdata != UNLOCK_KEY);
      if (wrOk && hitCtrl) ctrlReg <= busWdata[1:0];
      if (wrOk && hitLoad) loadReg <= loadNew;
    end
  end

  always_comb begin
    strobe.loadWr = wrOk & hitLoad;
    strobe.intClr = wrOk & hitIclr;
    strobe.cntEn  = ctrlReg[0];
    strobe.rstEn  = ctrlReg[1];
  end

  assign loadCur = loadReg;

  always_comb begin
    busRdata = '0;
    if (hitLoad)  busRdata = 32'(loadReg);
    if (hitCount) busRdata = 32'(count);
    if (hitCtrl)  busRdata = {30'b0, ctrlReg};
    if (hitRaw)   busRdata = {31'b0, intRaw};
    if (hitMask)  busRdata = {31'b0, intRaw & ctrlReg[0]};
    if (hitKey)   busRdata = {31'b0, locked};
  end

  // R2
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWr && hitCtrl) |=> $stable(ctrlReg));
  // R2
  locked_load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWr && hitLoad) |=> $stable(loadReg));
  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadReg != '0);
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadNew,
  input  logic [CNT_W-1:0] loadCur,
  output logic [CNT_W-1:0] count,
  output logic             intRaw,
  output logic             rstOut
);
  localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};

  logic expire;
  assign expire = strobe.cntEn && (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= CNT_RST;
      intRaw <= 1'b0;
      rstOut <= 1'b0;
    end else begin
      if (strobe.loadWr)                count <= loadNew;
      else if (strobe.intClr || expire) count <= loadCur;
      else if (strobe.cntEn)            count <= count - 1'b1;

      if (strobe.intClr)  intRaw <= 1'b0;
      else if (expire)    intRaw <= 1'b1;

      if (expire && intRaw && !strobe.intClr && strobe.rstEn) rstOut <= 1'b1;
    end
  end

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntEn && count != '0 && !strobe.loadWr && !strobe.intClr)
      |=> count == $past(count) - 1'b1);
  // R5
  first_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !intRaw && !strobe.intClr) |=> intRaw);
  // R6
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstOut |=> rstOut);
  // R7
  clr_drops_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intClr |=> !intRaw);
  // R9
  clr_blocks_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.intClr && !rstOut) |=> !rstOut);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              sysRst
);
  wdtStrobe_t       strobe;
  logic [CNT_W-1:0] loadNew, loadCur, count;
  logic             intRaw;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .count(count), .intRaw(intRaw),
    .strobe(strobe), .loadNew(loadNew), .loadCur(loadCur),
    .busRdata(busRdata)
  );

  wdt_count #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadNew(loadNew),
    .loadCur(loadCur), .count(count), .intRaw(intRaw), .rstOut(sysRst)
  );

  assign irq = intRaw & strobe.cntEn;

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intRaw);
endmodule

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;
  import wdt_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, sysRst;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wdog_two_stage dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sysRst(sysRst)
  );

  // {chk, isWr, req[3:0], addr[11:0], data[31:0]}
  localparam int NV = 19;
  localparam logic [49:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 4'd1, OFS_LOAD,  32'hFFFF_FFFF}, // R1
    {1'b1, 1'b0, 4'd1, OFS_CTRL,  32'h0},         // R1
    {1'b1, 1'b0, 4'd1, OFS_KEY,   32'h1},         // R1
    {1'b1, 1'b0, 4'd1, OFS_COUNT, 32'hFFFF_FFFF}, // R1
    {1'b1, 1'b0, 4'd1, OFS_RAW,   32'h0},         // R1
    {1'b0, 1'b1, 4'd2, OFS_LOAD,  32'h10},        // R2 locked write
    {1'b1, 1'b0, 4'd2, OFS_LOAD,  32'hFFFF_FFFF}, // R2
    {1'b0, 1'b1, 4'd2, OFS_KEY,   UNLOCK_KEY},    // R2
    {1'b1, 1'b0, 4'd2, OFS_KEY,   32'h0},         // R2
    {1'b0, 1'b1, 4'd3, OFS_LOAD,  32'h20},        // R3
    {1'b1, 1'b0, 4'd3, OFS_LOAD,  32'h20},        // R3
    {1'b1, 1'b0, 4'd3, OFS_COUNT, 32'h20},        // R3
    {1'b0, 1'b1, 4'd3, OFS_LOAD,  32'h0},         // R3 zero clamps
    {1'b1, 1'b0, 4'd3, OFS_LOAD,  32'h1},         // R3
    {1'b0, 1'b1, 4'd2, OFS_KEY,   32'h2},         // R2 relock
    {1'b1, 1'b0, 4'd2, OFS_KEY,   32'h1},         // R2
    {1'b0, 1'b1, 4'd2, OFS_CTRL,  32'h1},         // R2 locked write
    {1'b1, 1'b0, 4'd2, OFS_CTRL,  32'h0},         // R2
    {1'b0, 1'b1, 4'd2, OFS_KEY,   UNLOCK_KEY}     // R2 unlock again
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    busAddr = a; busWr = 1'b0;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 sysRst", {31'b0, sysRst}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][43:32], VEC[i][31:0]);
      if (VEC[i][49]) rdChk($sformatf("R%0d vec%0d", VEC[i][47:44], i), VEC[i][43:32], VEC[i][31:0]);
    end

    // R4: hold when disabled, then decrement
    wr(OFS_LOAD, 32'd3);
    tick(2);
    rdChk("R4 hold", OFS_COUNT, 32'd3);
    wr(OFS_CTRL, 32'd1);
    rdChk("R4 start", OFS_COUNT, 32'd3);
    tick(1);
    rdChk("R4 dec", OFS_COUNT, 32'd2);
    tick(2);
    rdChk("R4 zero", OFS_COUNT, 32'd0);
    rdChk("R5 not yet", OFS_RAW, 32'd0);
    // R5 first expiry
    tick(1);
    rdChk("R5 raw", OFS_RAW, 32'd1);
    rdChk("R5 reload", OFS_COUNT, 32'd3);
    rdChk("R8 masked", OFS_MASK, 32'd1);
    check("R8 irq", {31'b0, irq}, 32'h1);
    // R6 second expiry without reset enable
    tick(4);
    check("R6 no rst when disabled", {31'b0, sysRst}, 32'h0);
    rdChk("R6 reload", OFS_COUNT, 32'd3);
    rdChk("R6 still pending", OFS_RAW, 32'd1);
    // R8 masking
    wr(OFS_CTRL, 32'd0);
    rdChk("R8 mask off", OFS_MASK, 32'd0);
    rdChk("R8 raw kept", OFS_RAW, 32'd1);
    check("R8 irq off", {31'b0, irq}, 32'h0);
    // R7 clear
    wr(OFS_ICLR, 32'h55);
    rdChk("R7 cleared", OFS_RAW, 32'd0);
    rdChk("R7 reload", OFS_COUNT, 32'd3);
    // R9 clear on first expiry edge
    wr(OFS_CTRL, 32'd1);
    tick(3);
    rdChk("R9 at zero", OFS_COUNT, 32'd0);
    wr(OFS_ICLR, 32'h0);
    rdChk("R9 no int", OFS_RAW, 32'd0);
    rdChk("R9 reload", OFS_COUNT, 32'd3);
    // R6 reset path
    wr(OFS_CTRL, 32'd3);
    tick(3);
    rdChk("R6 first stage", OFS_RAW, 32'd1);
    tick(3);
    rdChk("R6 zero", OFS_COUNT, 32'd0);
    check("R6 before", {31'b0, sysRst}, 32'h0);
    tick(1);
    check("R6 asserted", {31'b0, sysRst}, 32'h1);
    wr(OFS_ICLR, 32'h0);
    tick(2);
    check("R6 sticky", {31'b0, sysRst}, 32'h1);
    doReset();
    check("R6 cleared by reset", {31'b0, sysRst}, 32'h0);
    rdChk("R1 relocked", OFS_KEY, 32'd1);
    // R9 clear on second expiry edge
    wr(OFS_KEY, UNLOCK_KEY);
    wr(OFS_LOAD, 32'd2);
    wr(OFS_CTRL, 32'd3);
    tick(3);
    rdChk("R9 pending", OFS_RAW, 32'd1);
    tick(2);
    rdChk("R9 zero2", OFS_COUNT, 32'd0);
    wr(OFS_ICLR, 32'h0);
    check("R9 no rst", {31'b0, sysRst}, 32'h0);
    rdChk("R9 int clear", OFS_RAW, 32'd0);
    rdChk("R9 reload2", OFS_COUNT, 32'd2);
    // R3 keep-alive beats decrement
    tick(1);
    rdChk("R3 run", OFS_COUNT, 32'd1);
    wr(OFS_LOAD, 32'd2);
    rdChk("R3 keepalive", OFS_COUNT, 32'd2);
    tick(1);
    rdChk("R3 after", OFS_COUNT, 32'd1);
    check("R3 no rst", {31'b0, sysRst}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule